// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer Pair

This block holds two 8-bit up-counters, named X and Y. Each one has two compare registers (A and B), two sticky match flags, a counter-clear selector, an external clear pin and an output pin. Each counter takes its count enable from a small set of prescaled clock enables supplied from outside. A synchronous register port sets up the pair and reads back its state.

A channel whose clock-select code is 3'b100 takes its count event from the other channel. Two mode bits then choose how the pair is chained. With Y chained and the Y mode bit set, X and Y form one 16-bit counter: X is the low byte and Y is the high byte. Clears, flags and pins still work byte by byte. With X chained and the X mode bit set, X counts the compare-match A events of Y, and the two channels otherwise run independently.

A match is an event, not a level. It fires on the first cycle in which a counter, having just been advanced or cleared, equals a compare value. A counter that sits still on the compare value produces only one match, and writing the counter directly produces none.

Top module: `tmr_pair`

## Requirements
- R1: After reset, the counters, control, output-select and mode registers, the flags and both pins read 0, and every compare register reads 8'hFF.
- R2: Register map, with addr[3] selecting the channel (0 = X, 1 = Y) and addr[2:0] selecting the register: 0 = control {clear[4:3], clock select[2:0]}, 1 = counter, 2 = compare A, 3 = compare B, 4 = flags {B[1], A[0]}, 5 = pin ops {B op[3:2], A op[1:0]}, 6 = mode {Y chain[1], X chain[0]} (shared by both halves). Clock-select code n in 1..3 counts on each cycle where prescale enable n-1 is high. Code 0 and any unused code hold the counter.
- R3: The 8-bit counter wraps from 8'hFF to 8'h00. A match on A or B is detected in the cycle after the counter reaches the compare value by counting or clearing, and it sets that flag at the following edge.
- R4: Flags stay set until a write to the flags register puts 0 in that bit. Writing 1 leaves the flag unchanged.
- R5: Clear codes: 00 = none, 01 = clear on match A, 10 = clear on match B, 11 = clear on a rising edge of the channel's external clear pin. A level held high does not clear again. A clear takes priority over a count in the same cycle.
- R6: Pin op codes: 00 = keep, 01 = drive low, 10 = drive high, 11 = toggle. When matches A and B occur in the same cycle, the B op is applied.
- R7: 16-bit mode (Y clock select 3'b100 and Y chain bit set): Y increments in the cycle where X counts from 8'hFF to 8'h00.
- R8: In 16-bit mode, Y's clears (match or external) reset only Y. X's own clear setting still resets X, and a clear of X never carries into Y.
- R9: In 16-bit mode, Y's flags and pin respond only to Y (upper byte) matches, and X's flags and pin respond only to X (lower byte) matches.
- R10: Compare-match count mode (X clock select 3'b100 and X chain bit set): X increments once per match A event of Y. Each channel's flags, pin and clears stay independent.
- R11: A channel with clock select 3'b100 whose chain bit is 0 does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_en_i | input | N_PRE | Prescaled count enables |
| clr_x_i | input | 1 | External clear for X (synchronous to clk_i) |
| clr_y_i | input | 1 | External clear for Y (synchronous to clk_i) |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data, combinational from addr_i |
| tmo_x_o | output | 1 | Output pin of X |
| tmo_y_o | output | 1 | Output pin of Y |

## Verification
The bench targets the carry from the low byte into the high byte. A design that carries on a clear of X, or ignores the Y chain bit, leaves the upper byte one count off. The 16-bit tests check that a Y clear leaves X untouched and that flags stay on their own byte. A design that clears the whole 16-bit word, or raises flags on both channels, fails them. Other tests cover match B priority on the pin, a held external clear that must not clear twice, and match-A event counting, where level-based matching would over-count X.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] CKS_CASC = 3'b100;

  localparam logic [2:0] OFF_CTL  = 3'd0;
  localparam logic [2:0] OFF_CNT  = 3'd1;
  localparam logic [2:0] OFF_CMPA = 3'd2;
  localparam logic [2:0] OFF_CMPB = 3'd3;
  localparam logic [2:0] OFF_STAT = 3'd4;
  localparam logic [2:0] OFF_OS   = 3'd5;
  localparam logic [2:0] OFF_MODE = 3'd6;

  typedef enum logic [1:0] {CLR_NONE, CLR_MA, CLR_MB, CLR_EXT} clr_sel_e;
  typedef enum logic [1:0] {PIN_KEEP, PIN_LOW, PIN_HIGH, PIN_TOG} pin_op_e;

  typedef struct packed {
    clr_sel_e   clr;
    logic [2:0] cks;
  } ctl_t;

  typedef struct packed {
    pin_op_e op_b;
    pin_op_e op_a;
  } os_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  clr_sel_e     clr_sel_i,
  input  logic         ext_clr_i,
  input  logic         cnt_we_i,
  input  logic         cmpa_we_i,
  input  logic         cmpb_we_i,
  input  logic         stat_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmpa_o,
  output logic [W-1:0] cmpb_o,
  output logic [1:0]   flags_o,
  output logic         match_a_o,
  output logic         match_b_o,
  output logic         clr_o,
  output logic         carry_o
);
  logic [W-1:0] cnt_q, cmpa_q, cmpb_q;
  logic [1:0]   flags_q;
  logic         upd_q, ext_q, ext_rise, clr;

  assign ext_rise  = ext_clr_i & ~ext_q;
  assign match_a_o = upd_q && (cnt_q == cmpa_q);
  assign match_b_o = upd_q && (cnt_q == cmpb_q);

  always_comb begin
    unique case (clr_sel_i)
      CLR_MA:  clr = match_a_o;
      CLR_MB:  clr = match_b_o;
      CLR_EXT: clr = ext_rise;
      default: clr = 1'b0;
    endcase
  end

  assign clr_o   = clr;
  // low-byte wrap by counting only
  assign carry_o = tick_i && !clr && !cnt_we_i && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cmpa_q  <= '1;
      cmpb_q  <= '1;
      flags_q <= '0;
      upd_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      ext_q <= ext_clr_i;
      upd_q <= !cnt_we_i && (clr || tick_i);
      if (cnt_we_i)    cnt_q <= wdata_i;
      else if (clr)    cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (cmpa_we_i) cmpa_q <= wdata_i;
      if (cmpb_we_i) cmpb_q <= wdata_i;
      if (stat_we_i) flags_q <= (flags_q & wdata_i[1:0]) | {match_b_o, match_a_o};
      else           flags_q <= flags_q | {match_b_o, match_a_o};
    end
  end

  assign cnt_o   = cnt_q;
  assign cmpa_o  = cmpa_q;
  assign cmpb_o  = cmpb_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_a_i,
  input  logic match_b_i,
  input  os_t  os_i,
  output logic pin_o
);
  pin_op_e op;
  logic    pin_q;

  always_comb begin
    if (match_b_i)      op = os_i.op_b;
    else if (match_a_i) op = os_i.op_a;
    else                op = PIN_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else begin
      unique case (op)
        PIN_LOW:  pin_q <= 1'b0;
        PIN_HIGH: pin_q <= 1'b1;
        PIN_TOG:  pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned N_PRE = 3,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PRE-1:0] presc_en_i,
  input  logic             clr_x_i,
  input  logic             clr_y_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic             tmo_x_o,
  output logic             tmo_y_o
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned CTL_W = $bits(ctl_t);
  localparam int unsigned OS_W  = $bits(os_t);

  ctl_t       ctl_q [NCH];
  os_t        os_q  [NCH];
  logic [1:0] mode_q;

  logic       ch;
  logic [2:0] off;
  logic [NCH-1:0] we_ch;

  assign ch  = addr_i[3];
  assign off = addr_i[2:0];

  for (genvar i = 0; i < NCH; i++) begin : g_we
    assign we_ch[i] = wr_i && (ch == 1'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        ctl_q[i] <= '0;
        os_q[i]  <= '0;
      end
      mode_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (we_ch[i] && off == OFF_CTL) ctl_q[i] <= ctl_t'(wdata_i[CTL_W-1:0]);
        if (we_ch[i] && off == OFF_OS)  os_q[i]  <= os_t'(wdata_i[OS_W-1:0]);
      end
      if (wr_i && off == OFF_MODE) mode_q <= wdata_i[1:0];
    end
  end

  logic mode16, cmcnt;
  assign mode16 = (ctl_q[1].cks == CKS_CASC) && mode_q[1];
  assign cmcnt  = (ctl_q[0].cks == CKS_CASC) && mode_q[0];

  function automatic logic sel_tick(input logic [2:0] cks,
                                    input logic [N_PRE-1:0] pre,
                                    input logic casc);
    logic t;
    t = 1'b0;
    if (cks == CKS_CASC) t = casc;
    else for (int i = 0; i < N_PRE; i++) if (int'(cks) == i + 1) t = pre[i];
    return t;
  endfunction

  logic [W-1:0] cnt_x, cnt_y, cmpa_x, cmpa_y, cmpb_x, cmpb_y;
  logic [1:0]   flags_x, flags_y;
  logic         x_ma, x_mb, y_ma, y_mb, x_clr, y_clr, x_carry, y_carry;
  logic         x_tick, y_tick;

  assign x_tick = sel_tick(ctl_q[0].cks, presc_en_i, mode_q[0] & y_ma);
  assign y_tick = sel_tick(ctl_q[1].cks, presc_en_i, mode_q[1] & x_carry);

  tmr_chan #(.W(W)) u_chan_x (
    .clk_i, .rst_ni,
    .tick_i    (x_tick),
    .clr_sel_i (ctl_q[0].clr),
    .ext_clr_i (clr_x_i),
    .cnt_we_i  (we_ch[0] && off == OFF_CNT),
    .cmpa_we_i (we_ch[0] && off == OFF_CMPA),
    .cmpb_we_i (we_ch[0] && off == OFF_CMPB),
    .stat_we_i (we_ch[0] && off == OFF_STAT),
    .wdata_i,
    .cnt_o     (cnt_x),
    .cmpa_o    (cmpa_x),
    .cmpb_o    (cmpb_x),
    .flags_o   (flags_x),
    .match_a_o (x_ma),
    .match_b_o (x_mb),
    .clr_o     (x_clr),
    .carry_o   (x_carry)
  );

  tmr_chan #(.W(W)) u_chan_y (
    .clk_i, .rst_ni,
    .tick_i    (y_tick),
    .clr_sel_i (ctl_q[1].clr),
    .ext_clr_i (clr_y_i),
    .cnt_we_i  (we_ch[1] && off == OFF_CNT),
    .cmpa_we_i (we_ch[1] && off == OFF_CMPA),
    .cmpb_we_i (we_ch[1] && off == OFF_CMPB),
    .stat_we_i (we_ch[1] && off == OFF_STAT),
    .wdata_i,
    .cnt_o     (cnt_y),
    .cmpa_o    (cmpa_y),
    .cmpb_o    (cmpb_y),
    .flags_o   (flags_y),
    .match_a_o (y_ma),
    .match_b_o (y_mb),
    .clr_o     (y_clr),
    .carry_o   (y_carry)
  );

  logic [NCH-1:0] ma_v, mb_v, tmo_v;
  assign ma_v = {y_ma, x_ma};
  assign mb_v = {y_mb, x_mb};

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    tmr_pin u_pin (
      .clk_i, .rst_ni,
      .match_a_i (ma_v[i]),
      .match_b_i (mb_v[i]),
      .os_i      (os_q[i]),
      .pin_o     (tmo_v[i])
    );
  end

  assign tmo_x_o = tmo_v[0];
  assign tmo_y_o = tmo_v[1];

  always_comb begin
    rdata_o = '0;
    unique case (off)
      OFF_CTL:  rdata_o[CTL_W-1:0] = ctl_q[ch];
      OFF_CNT:  rdata_o = ch ? cnt_y  : cnt_x;
      OFF_CMPA: rdata_o = ch ? cmpa_y : cmpa_x;
      OFF_CMPB: rdata_o = ch ? cmpb_y : cmpb_x;
      OFF_STAT: rdata_o[1:0] = ch ? flags_y : flags_x;
      OFF_OS:   rdata_o[OS_W-1:0] = os_q[ch];
      OFF_MODE: rdata_o[1:0] = mode_q;
      default:  rdata_o = '0;
    endcase
  end

  logic unused_carry;
  assign unused_carry = y_carry;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  cnt_x,
  input logic [W-1:0]  cnt_y,
  input logic [1:0]    flags_x,
  input logic          x_tick,
  input logic          x_clr,
  input logic          y_clr,
  input logic          x_carry,
  input logic          x_ma,
  input logic          x_mb,
  input logic          y_ma,
  input logic          mode16,
  input logic          cmcnt,
  input logic          tmo_x_o
);
  logic wr_cnt_x, wr_cnt_y, wr_stat_x;
  assign wr_cnt_x  = wr_i && addr_i == AW'(1);
  assign wr_cnt_y  = wr_i && addr_i == AW'(9);
  assign wr_stat_x = wr_i && addr_i == AW'(4);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_tick && !x_clr && !wr_cnt_x) |=> $stable(cnt_x));

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_x[0] && !wr_stat_x) |=> flags_x[0]);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_clr && !wr_cnt_x) |=> (cnt_x == '0));

  p_pin_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_ma || x_mb) |=> $stable(tmo_x_o));

  p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode16 && x_carry && !y_clr && !wr_cnt_y) |=> (cnt_y == W'($past(cnt_y) + 1'b1)));

  p_cm_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmcnt && y_ma && !x_clr && !wr_cnt_x) |=> (cnt_x == W'($past(cnt_x) + 1'b1)));
endmodule

bind tmr_pair tmr_pair_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .cnt_x   (cnt_x),
  .cnt_y   (cnt_y),
  .flags_x (flags_x),
  .x_tick  (x_tick),
  .x_clr   (x_clr),
  .y_clr   (y_clr),
  .x_carry (x_carry),
  .x_ma    (x_ma),
  .x_mb    (x_mb),
  .y_ma    (y_ma),
  .mode16  (mode16),
  .cmcnt   (cmcnt),
  .tmo_x_o (tmo_x_o)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  localparam logic [3:0] X_CTL = 4'h0, X_CNT = 4'h1, X_CMPA = 4'h2, X_CMPB = 4'h3,
                         X_STAT = 4'h4, X_OS = 4'h5, MODE = 4'h6;
  localparam logic [3:0] Y_CTL = 4'h8, Y_CNT = 4'h9, Y_CMPA = 4'hA, Y_CMPB = 4'hB,
                         Y_STAT = 4'hC;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] presc_en_i = 3'b001;
  logic       clr_x_i = 1'b0, clr_y_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       tmo_x_o, tmo_y_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  tmr_pair uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // enable at one edge, disable at the edge k-1 cycles later: k counting edges
  task automatic run(input logic [3:0] a, input logic [7:0] on, input logic [7:0] off, input int k);
    wr(a, on);
    repeat (k - 1) @(negedge clk_i);
    wr(a, off);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(X_CNT, d);  chk("R1 cnt x", d, 8'h00);
    rd(X_CMPA, d); chk("R1 cmpa x", d, 8'hFF);
    rd(Y_CMPB, d); chk("R1 cmpb y", d, 8'hFF);
    rd(Y_CTL, d);  chk("R1 ctl y", d, 8'h00);
    rd(X_STAT, d); chk("R1 flags x", d, 8'h00);
    chk("R1 pins", {6'b0, tmo_y_o, tmo_x_o}, 8'h00);
  endtask

  task automatic t_wrap_flags;
    logic [7:0] d;
    wr(X_CNT, 8'hFE);
    run(X_CTL, 8'h01, 8'h00, 3);
    rd(X_CNT, d);  chk("R3 wrap", d, 8'h01);
    rd(Y_CNT, d);  chk("R2 y idle", d, 8'h00);
    rd(X_STAT, d); chk("R3 flags set", d, 8'h03);
    wr(X_STAT, 8'h01);
    rd(X_STAT, d); chk("R4 write0 clears/write1 keeps", d, 8'h01);
    wr(X_STAT, 8'h00);
    rd(X_STAT, d); chk("R4 cleared", d, 8'h00);
  endtask

  task automatic t_presc_sel;
    logic [7:0] d;
    run(X_CTL, 8'h02, 8'h00, 5);  // enable 1 is held low
    rd(X_CNT, d); chk("R2 unselected enable", d, 8'h01);
  endtask

  task automatic t_clear_toggle;
    logic [7:0] d;
    wr(X_CNT, 8'h00); wr(X_CMPA, 8'h03); wr(X_OS, 8'h03);
    run(X_CTL, 8'h09, 8'h08, 6);
    rd(X_CNT, d);  chk("R5 clear on A", d, 8'h02);
    chk("R6 toggle", {7'b0, tmo_x_o}, 8'h01);
    rd(X_STAT, d); chk("R3 flag A only", d, 8'h01);
  endtask

  task automatic t_b_priority;
    wr(X_CTL, 8'h00);
    wr(X_CNT, 8'h01); wr(X_CMPA, 8'h02); wr(X_CMPB, 8'h02); wr(X_OS, 8'h06);
    run(X_CTL, 8'h01, 8'h00, 2);
    @(negedge clk_i);
    chk("R6 B wins", {7'b0, tmo_x_o}, 8'h00);
  endtask

  task automatic t_ext_clear;
    logic [7:0] d;
    wr(Y_CTL, 8'h18); wr(Y_CNT, 8'h40);
    clr_x_i = 1'b1; @(negedge clk_i); clr_x_i = 1'b0; @(negedge clk_i);
    rd(Y_CNT, d); chk("R5 other pin ignored", d, 8'h40);
    clr_y_i = 1'b1; @(negedge clk_i);
    rd(Y_CNT, d); chk("R5 rising edge clears", d, 8'h00);
    wr(Y_CNT, 8'h40); @(negedge clk_i);
    rd(Y_CNT, d); chk("R5 held level no clear", d, 8'h40);
    clr_y_i = 1'b0;
  endtask

  task automatic t_16bit;
    logic [7:0] d;
    wr(Y_CTL, 8'h04); wr(MODE, 8'h02); wr(Y_CNT, 8'h12);
    wr(X_CMPA, 8'h80); wr(X_CMPB, 8'h80); wr(X_OS, 8'h00);
    wr(X_CNT, 8'hFE);
    run(X_CTL, 8'h01, 8'h00, 3);
    rd(X_CNT, d); chk("R7 low byte", d, 8'h01);
    rd(Y_CNT, d); chk("R7 carry", d, 8'h13);
  endtask

  task automatic t_16bit_upper_clear;
    logic [7:0] d;
    wr(X_STAT, 8'h00); wr(Y_STAT, 8'h00);
    wr(Y_CMPA, 8'h14); wr(Y_CTL, 8'h0C); wr(X_CNT, 8'hFF);
    run(X_CTL, 8'h01, 8'h00, 3);
    rd(Y_CNT, d);  chk("R8 upper cleared", d, 8'h00);
    rd(X_CNT, d);  chk("R8 lower kept", d, 8'h02);
    rd(Y_STAT, d); chk("R9 upper flag", d, 8'h01);
    rd(X_STAT, d); chk("R9 lower flag clear", d, 8'h00);
  endtask

  task automatic t_16bit_lower_clear;
    logic [7:0] d;
    wr(Y_CTL, 8'h04); wr(Y_CNT, 8'h20); wr(X_CNT, 8'h00); wr(X_CMPA, 8'h03);
    run(X_CTL, 8'h09, 8'h08, 5);
    rd(X_CNT, d); chk("R8 lower own clear", d, 8'h01);
    rd(Y_CNT, d); chk("R8 no carry on clear", d, 8'h20);
  endtask

  task automatic t_chain_off;
    logic [7:0] d;
    wr(MODE, 8'h00); wr(X_CTL, 8'h00); wr(X_CMPA, 8'h80); wr(X_CNT, 8'hFE);
    run(X_CTL, 8'h01, 8'h00, 3);
    rd(Y_CNT, d); chk("R11 chain bit 0 holds", d, 8'h20);
  endtask

  task automatic t_cm_count;
    logic [7:0] d;
    wr(MODE, 8'h01); wr(X_CTL, 8'h04); wr(X_CNT, 8'h00);
    wr(Y_CNT, 8'h00); wr(Y_CMPA, 8'h02);
    wr(X_STAT, 8'h00); wr(Y_STAT, 8'h00);
    run(Y_CTL, 8'h09, 8'h08, 6);
    rd(X_CNT, d);  chk("R10 counts Y match A", d, 8'h02);
    rd(Y_CNT, d);  chk("R10 Y own clear", d, 8'h00);
    rd(Y_STAT, d); chk("R10 Y flag", d, 8'h01);
    rd(X_STAT, d); chk("R10 X flags independent", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_wrap_flags;
    t_presc_sel;
    t_clear_toggle;
    t_b_priority;
    t_ext_clear;
    t_16bit;
    t_16bit_upper_clear;
    t_16bit_lower_clear;
    t_chain_off;
    t_cm_count;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule